// File: doc/BRIEF.md
# Enhanced-Mode Unlock and Register Bank Selector

This block guards the entry into the enhanced register set of a port-addressed peripheral. It observes every bus access (write strobe, read strobe, port address, data byte). After reset the peripheral runs in standard mode. Enhanced mode is entered only after a fixed four-byte key has been written to the selector port with nothing else in between.

Once unlocked, the selector port becomes a bank select register. Its two top data bits pick register bank 0 (input levels), bank 1 (event flags) or bank 2 (debounce setup). Reading the selector port returns the current bank in the same field. Enhanced mode is kept until the next reset. The decoders of the other registers use the `enhanced` and `bank` outputs to route their accesses.

Top module: `mode_unlock_bank_sel`

## Requirements
- R1: Out of reset, `enhanced` is 0, `bank` is 0 and `rdata` is 0.
- R2: Writes of 07h, 0Dh, 06h and 12h, in that order, to port 7 (address 3'd7) set `enhanced` to 1 with `bank` 0 on the clock edge that takes the fourth write.
- R3: A read or write to any port other than 7 before the key is complete resets the key progress, so the full four-byte key is needed again.
- R4: A write to port 7 of a byte other than the expected key byte resets the key progress. If that byte is 07h, it counts as the first key byte of a new attempt.
- R5: Reads of port 7 in standard mode do not disturb the key progress.
- R6: In enhanced mode, a write to port 7 loads `bank` from data bits 7:6 on the next edge. Code 00 selects bank 0, 01 selects bank 1 and 10 selects bank 2. Bits 5:0 are ignored.
- R7: In enhanced mode, a write to port 7 whose bits 7:6 are 11 leaves `bank` unchanged.
- R8: While `rd_en` is high with address 7 in enhanced mode, `rdata` shows the bank code in bits 7:6 and zeros in bits 5:0, in the same cycle. In every other case `rdata` is 0.
- R9: Enhanced mode stays set until reset. Writing the key again only acts as bank selects.
- R10: In standard mode `bank` stays 0 whatever is written to port 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| addr | input | 3 | Port address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Bank status read data for port 7 |
| enhanced | output | 1 | Enhanced mode active |
| bank | output | 2 | Selected register bank |

## Verification
The assertions assume that the bus never raises the write and read strobes in the same cycle. One of them checks this assumption. The stimulus keeps to it by drawing a single access kind per cycle (idle, read or write). It leans on address 7 and on the key bytes, so that complete and broken key sequences both occur often. Directed cases cover breaks by other ports, a wrong byte equal to 07h, reads in the middle of the key, the reserved bank code 11 and a second key after unlock.

// File: rtl/mode_unlock_bank_sel.sv
module mode_unlock_bank_sel #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SEL_PORT = 7,
  parameter logic [DATA_W-1:0] KEY0 = 8'h07,
  parameter logic [DATA_W-1:0] KEY1 = 8'h0D,
  parameter logic [DATA_W-1:0] KEY2 = 8'h06,
  parameter logic [DATA_W-1:0] KEY3 = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              enhanced,
  output logic [1:0]        bank
);

  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_PORT);
  localparam logic [1:0] BANK_RSVD = 2'b11;

  logic [1:0]        step_q;
  logic              enh_q;
  logic [1:0]        bank_q;
  logic [DATA_W-1:0] want_byte;

  wire sel_hit   = (addr == SEL_ADDR);
  wire sel_wr    = wr_en && sel_hit;
  wire other_acc = (wr_en || rd_en) && !sel_hit;
  wire [1:0] code = wdata[DATA_W-1 -: 2];

  always_comb begin
    case (step_q)
      2'd0:    want_byte = KEY0;
      2'd1:    want_byte = KEY1;
      2'd2:    want_byte = KEY2;
      default: want_byte = KEY3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      enh_q  <= 1'b0;
      bank_q <= '0;
    end else if (!enh_q) begin
      if (sel_wr) begin
        if (wdata == want_byte) begin
          if (step_q == 2'd3) begin
            enh_q  <= 1'b1;
            bank_q <= '0;
            step_q <= '0;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end else if (wdata == KEY0) begin
          step_q <= 2'd1;
        end else begin
          step_q <= '0;
        end
      end else if (other_acc) begin
        step_q <= '0;
      end
    end else if (sel_wr && code != BANK_RSVD) begin
      bank_q <= code;
    end
  end

  assign enhanced = enh_q;
  assign bank     = bank_q;
  assign rdata    = (enh_q && rd_en && sel_hit) ? {bank_q, {(DATA_W-2){1'b0}}} : '0;

endmodule

// File: rtl/mode_unlock_bank_sel_chk.sv
module mode_unlock_bank_sel_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SEL_PORT = 7,
  parameter logic [DATA_W-1:0] KEY3 = 8'h12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              enhanced,
  input logic [1:0]        bank
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_PORT);

  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    was_rst |-> (!enhanced && bank == 2'd0)); // R1
  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!was_rst && $rose(enhanced)) |-> ($past(wr_en) && $past(addr) == SEL_ADDR && $past(wdata) == KEY3 && bank == 2'd0)); // R2
  AST_ENH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    enhanced |=> enhanced); // R9
  AST_STD_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !enhanced |-> bank == 2'd0); // R10
  AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bank != 2'b11); // R7
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enhanced && !(wr_en && addr == SEL_ADDR)) |=> $stable(bank)); // R6
  AST_RDATA_STD: assert property (@(posedge clk) disable iff (!rst_n)
    !enhanced |-> rdata == '0); // R8
endmodule

bind mode_unlock_bank_sel mode_unlock_bank_sel_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_PORT(SEL_PORT), .KEY3(KEY3)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .enhanced(enhanced), .bank(bank)
);

// File: tb/mode_unlock_bank_sel_tb.sv
`timescale 1ns/1ps
module mode_unlock_bank_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic enhanced;
  logic [1:0] bank;

  int tests = 0, fails = 0;
  bit done = 0;

  bit m_enh;
  int m_step;
  logic [1:0] m_bank;

  always #2 clk = ~clk;

  mode_unlock_bank_sel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .enhanced(enhanced), .bank(bank));

  function automatic logic [7:0] key_at(int i);
    case (i)
      0: return 8'h07;
      1: return 8'h0D;
      2: return 8'h06;
      default: return 8'h12;
    endcase
  endfunction

  function automatic logic [7:0] exp_rdata(bit e, logic [1:0] b, logic r, logic [2:0] a);
    return (e && r && a == 3'd7) ? {b, 6'b0} : 8'h00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge(logic w, logic r, logic [2:0] a, logic [7:0] d);
    if (!m_enh) begin
      if (w && a == 3'd7) begin
        if (d == key_at(m_step)) begin
          if (m_step == 3) begin m_enh = 1; m_bank = 0; m_step = 0; end
          else m_step++;
        end else m_step = (d == 8'h07) ? 1 : 0;
      end else if ((w || r) && a != 3'd7) m_step = 0;
    end else if (w && a == 3'd7 && d[7:6] != 2'b11) m_bank = d[7:6];
  endtask

  task automatic access(string req, logic w, logic r, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1 check({req, " rdata"}, rdata, exp_rdata(m_enh, m_bank, r, a));
    model_edge(w, r, a, d);
    @(negedge clk);
    check({req, " enhanced"}, enhanced, m_enh);
    check({req, " bank"}, bank, m_bank);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0;
    m_enh = 0; m_step = 0; m_bank = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_key(string req);
    for (int i = 0; i < 4; i++) access(req, 1, 0, 3'd7, key_at(i));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    check("R1 enhanced", enhanced, 0);
    check("R1 bank", bank, 0);
    rd_en = 1; addr = 3'd7; #1 check("R1 rdata", rdata, 0); rd_en = 0;

    access("R10", 1, 0, 3'd7, 8'h80);
    check("R10 bank stays 0", bank, 0);
    send_key("R2");
    check("R2 unlocked", enhanced, 1);
    check("R2 bank0", bank, 0);

    do_reset();
    access("R3", 1, 0, 3'd7, 8'h07); access("R3", 1, 0, 3'd7, 8'h0D);
    access("R3", 0, 1, 3'd2, 8'h00);
    access("R3", 1, 0, 3'd7, 8'h06); access("R3", 1, 0, 3'd7, 8'h12);
    check("R3 still locked", enhanced, 0);
    access("R3", 1, 0, 3'd7, 8'h07); access("R3", 1, 0, 3'd4, 8'h0D);
    access("R3", 1, 0, 3'd7, 8'h0D); access("R3", 1, 0, 3'd7, 8'h06);
    access("R3", 1, 0, 3'd7, 8'h12);
    check("R3 locked after write break", enhanced, 0);

    do_reset();
    access("R4", 1, 0, 3'd7, 8'h07); access("R4", 1, 0, 3'd7, 8'h0D);
    access("R4", 1, 0, 3'd7, 8'h07);
    access("R4", 1, 0, 3'd7, 8'h0D); access("R4", 1, 0, 3'd7, 8'h06);
    access("R4", 1, 0, 3'd7, 8'h12);
    check("R4 restart on 07", enhanced, 1);

    do_reset();
    access("R4", 1, 0, 3'd7, 8'h07); access("R4", 1, 0, 3'd7, 8'h33);
    access("R4", 1, 0, 3'd7, 8'h0D); access("R4", 1, 0, 3'd7, 8'h06);
    access("R4", 1, 0, 3'd7, 8'h12);
    check("R4 wrong byte resets", enhanced, 0);

    do_reset();
    access("R5", 1, 0, 3'd7, 8'h07); access("R5", 0, 1, 3'd7, 8'h00);
    access("R5", 1, 0, 3'd7, 8'h0D); access("R5", 0, 1, 3'd7, 8'h00);
    access("R5", 1, 0, 3'd7, 8'h06); access("R5", 1, 0, 3'd7, 8'h12);
    check("R5 reads keep progress", enhanced, 1);

    access("R6", 1, 0, 3'd7, 8'h80); check("R6 bank2", bank, 2);
    access("R8", 0, 1, 3'd7, 8'h00);
    access("R6", 1, 0, 3'd7, 8'h7F); check("R6 bank1 low bits ignored", bank, 1);
    access("R8", 0, 1, 3'd7, 8'h00);
    access("R7", 1, 0, 3'd7, 8'hC5); check("R7 reserved ignored", bank, 1);
    access("R8", 0, 1, 3'd3, 8'h00);
    access("R6", 1, 0, 3'd7, 8'h00); check("R6 bank0", bank, 0);
    access("R6", 1, 0, 3'd7, 8'h80);
    send_key("R9");
    check("R9 still enhanced", enhanced, 1);
    check("R9 key acts as bank write", bank, 0);

    for (int round = 0; round < 40; round++) begin
      do_reset();
      for (int n = 0; n < 200; n++) begin
        int kind = $urandom_range(0, 9);
        logic [2:0] a = ($urandom_range(0, 3) != 0) ? 3'd7 : 3'($urandom_range(0, 7));
        logic [7:0] d;
        int pick = $urandom_range(0, 9);
        if (pick < 3) d = key_at(m_step);
        else if (pick < 5) d = key_at($urandom_range(0, 3));
        else d = 8'($urandom);
        if (kind < 6) access("R2 R6 random", 1, 0, a, d);
        else if (kind < 8) access("R8 random", 0, 1, a, d);
        else access("R5 random idle", 0, 0, a, d);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule